// File: doc/BRIEF.md
# Sampling Converter Control with Two-Byte Parallel Readout

This block is the synchronous digital control and parallel read port of a 12-bit sampling converter. A host starts a conversion by pulling two active-low selects (chip select and read/convert) low together, in either order. The block then drops its BUSY flag for a fixed number of system clock cycles. When that time is up it loads a 12-bit two's-complement sample from its sample input into the result register and raises BUSY again.

The host reads the result over an 8-bit bus in two halves, picked by a byte-select input. The bus is enabled only while read/convert is high and chip select is low. Outside that window the enable output is low, and this enable stands for the high-impedance state. A power-down input stops new conversions and abandons one that is running. The stored result stays readable while power-down is high.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, busy is high and the result register holds zero, so an enabled read returns 0x00 on both byte selections.
- R2: A conversion starts on the first clock edge at which cs_n and rc_n are both low, power-down is low and busy is high. The order in which the two selects fell does not matter. busy is low after that edge.
- R3: busy stays low for exactly CONV_CYCLES clock cycles. On the edge where busy rises, sample_in is loaded unchanged as a two's-complement word into the result register. The result register does not change on any other edge.
- R4: A start condition that appears while busy is low is ignored and does not shorten or lengthen the running conversion.
- R5: If both selects are still low on the clock edge after busy rises, a new conversion starts at once. busy is then high for exactly one cycle.
- R6: bus_oe is 1 only when rc_n is 1 and cs_n is 0, and 0 for the other three combinations.
- R7: With byte_sel = 0 and the bus enabled, bus_data[7:0] equals result bits 11..4, with result bit 11 on bus bit 7.
- R8: With byte_sel = 1 and the bus enabled, bus_data[7:4] equals result bits 3..0 and bus_data[3:0] is 0. A change of byte_sel changes bus_data in the same cycle, without waiting for a clock edge.
- R9: While pwrdn is 1, no conversion starts, busy stays high and the previous result stays readable.
- R10: Raising pwrdn during a conversion ends it on the next clock edge. busy goes high on that edge and the result register keeps its previous value.
- R11: While bus_oe is 0, bus_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, level sensitive |
| rc_n | input | 1 | Read/convert select: low requests a conversion, high requests a read |
| pwrdn | input | 1 | Power-down, active high |
| byte_sel | input | 1 | 0 selects the upper eight result bits, 1 selects the lower nibble |
| sample_in | input | 12 | Two's-complement sample loaded at the end of a conversion |
| busy | output | 1 | Low while a conversion is in progress |
| bus_data | output | 8 | Read bus data |
| bus_oe | output | 1 | Bus drive enable; 0 stands for high impedance |

## Verification
The assertions assume that every input is synchronous to clk and is changed only away from the rising edge. They also assume that power-down is the only way a conversion ends early, so the length check is skipped for any conversion that ended with pwrdn high. The bench drives all inputs on the falling edge and samples results a few nanoseconds later or at the next falling edge. When it wants a single conversion, it releases the selects on the first falling edge after the start. It keeps them low through the end of a conversion only in the deliberate retrigger case.

// File: rtl/adc_rd_pkg.sv
// Package: shared types for the converter control block.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rd_pkg;

    // Which half of the result the read bus presents.
    typedef enum logic {
        PICK_UPPER = 1'b0,
        PICK_LOWER = 1'b1
    } byte_pick_e;

endpackage

// File: rtl/conv_timer.sv
// conv_timer: owns BUSY and the conversion countdown.
// Starts a conversion when idle and a start request is seen without power-down.
// Ends it after CONV_CYCLES cycles (done pulses on the final edge), or at once on power-down.
// Assumes: start_req and pwrdn are synchronous to clk.
module conv_timer #(
    parameter int CONV_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic pwrdn,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Purpose: BUSY state and countdown of the remaining conversion cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (start_req && !pwrdn) begin
                busy_q <= 1'b0;
                cnt_q  <= LAST;
            end
        end else if (pwrdn || cnt_q == '0) begin
            busy_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: flag the edge on which a conversion completes normally.
    always_comb begin
        done = !busy_q && !pwrdn && (cnt_q == '0);
    end

    assign busy = busy_q;
endmodule

// File: rtl/result_reg.sv
// result_reg: holds the last completed conversion result.
// Assumes: load is a single-cycle pulse from the timer.
module result_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] q
);
    // Purpose: capture the sample when a conversion finishes, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/byte_mux.sv
// byte_mux: combinational read path from the result to the bus.
// The upper selection carries the top BUS_W result bits.
// The lower selection carries the remaining bits left-justified, with zero fill below.
// Assumes: BUS_W < RES_W <= 2*BUS_W.
module byte_mux
    import adc_rd_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             byte_sel,
    input  logic             oe,
    output logic [BUS_W-1:0] data
);
    localparam int LO_W  = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LO_W;

    byte_pick_e       pick;
    logic [BUS_W-1:0] upper;
    logic [BUS_W-1:0] lower;

    assign pick  = byte_pick_e'(byte_sel);
    assign upper = result[RES_W-1 -: BUS_W];

    generate
        if (PAD_W > 0) begin : g_pad
            assign lower = {result[LO_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign lower = result[LO_W-1:0];
        end
    endgenerate

    // Purpose: pick the half and force zeros while the bus is disabled.
    always_comb begin
        if (!oe) begin
            data = '0;
        end else if (pick == PICK_LOWER) begin
            data = lower;
        end else begin
            data = upper;
        end
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
// adc_readout_ctrl: top of the converter control and parallel read port.
// The two active-low selects are combined by OR and are level sensitive.
// A conversion request is both of them low together.
// Assumes: all inputs are synchronous to clk; sample_in is valid on the edge a conversion ends.
module adc_readout_ctrl #(
    parameter int CONV_CYCLES = 16,
    parameter int RES_W       = 12,
    parameter int BUS_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rc_n,
    input  logic             pwrdn,
    input  logic             byte_sel,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_oe
);
    logic             sel_low;
    logic             conv_done;
    logic [RES_W-1:0] res_q;

    // Purpose: decode the two selects into a convert request and a read enable.
    always_comb begin
        sel_low = !(cs_n || rc_n);
        bus_oe  = rc_n && !cs_n;
    end

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (sel_low),
        .pwrdn     (pwrdn),
        .busy      (busy),
        .done      (conv_done)
    );

    result_reg #(.RES_W(RES_W)) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (conv_done),
        .din   (sample_in),
        .q     (res_q)
    );

    byte_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
        .result   (res_q),
        .byte_sel (byte_sel),
        .oe       (bus_oe),
        .data     (bus_data)
    );
endmodule

// File: rtl/adc_readout_chk.sv
// adc_readout_chk: temporal checks on adc_readout_ctrl, attached by bind.
// Counts the cycles busy spends low, so that the conversion window needs no
// parameter-sized delay.
// Assumes: inputs are synchronous to clk.
module adc_readout_chk #(
    parameter int CONV_CYCLES = 16,
    parameter int RES_W       = 12,
    parameter int BUS_W       = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             rc_n,
    input logic             pwrdn,
    input logic             byte_sel,
    input logic             busy,
    input logic             bus_oe,
    input logic [BUS_W-1:0] bus_data,
    input logic [RES_W-1:0] res_q
);
    localparam int LW = $clog2(CONV_CYCLES + 2) + 1;
    localparam logic [LW-1:0] FULL = LW'(CONV_CYCLES);
    localparam logic [LW-1:0] PEN  = LW'(CONV_CYCLES - 1);
    localparam int LO_W = RES_W - BUS_W;

    logic [LW-1:0] lo_cnt;

    // Purpose: count consecutive cycles with busy low.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_cnt <= '0;
        else if (busy)  lo_cnt <= '0;
        else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end

    AST_START_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_n && !rc_n && !pwrdn) |=> !busy);                 // R2

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(pwrdn)) |-> (lo_cnt == FULL));          // R3

    AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(res_q));                              // R3

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pwrdn && lo_cnt < PEN) |=> !busy);                  // R4

    AST_PWRDN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pwrdn) |=> busy);                                     // R9

    AST_PWRDN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwrdn) |=> (busy && $stable(res_q)));                // R10

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));                                 // R11

    AST_LOWER_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && byte_sel) |-> (bus_data[BUS_W-LO_W-1:0] == '0));    // R8
endmodule

bind adc_readout_ctrl adc_readout_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .RES_W       (RES_W),
    .BUS_W       (BUS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rc_n     (rc_n),
    .pwrdn    (pwrdn),
    .byte_sel (byte_sel),
    .busy     (busy),
    .bus_oe   (bus_oe),
    .bus_data (bus_data),
    .res_q    (res_q)
);

// File: tb/tb_adc_readout_ctrl.sv
// Scoreboard bench: driver tasks push the expected result of each conversion.
// The monitor pops an entry and compares it against every word read from the bus.
module tb_adc_readout_ctrl;
    localparam int CONV = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, rc_n, pwrdn, byte_sel;
    logic [11:0] sample_in;
    logic        busy, bus_oe;
    logic [7:0]  bus_data;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [11:0] exp_q[$];
    logic [11:0] rd_word;
    event        rd_ev;

    always #10 clk = ~clk;

    adc_readout_ctrl #(.CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
        .byte_sel(byte_sel), .sample_in(sample_in), .busy(busy),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare each word read back against the scoreboard (R3, R7).
    always begin
        @(rd_ev);
        if (exp_q.size() == 0) chk("R3 unexpected read", 32'(rd_word), 32'hFFFF_FFFF);
        else chk("R3/R7 result word", 32'(rd_word), 32'(exp_q.pop_front()));
    end

    // Read both halves over the bus; the lower pad must be zero (R8).
    task automatic read_word();
        logic [7:0] hi;
        cs_n = 1'b0; rc_n = 1'b1; byte_sel = 1'b0;
        #2;
        chk("R6 oe on read", 32'(bus_oe), 32'd1);
        hi = bus_data;
        byte_sel = 1'b1;
        #2;
        chk("R8 lower pad", 32'(bus_data[3:0]), 32'd0);
        rd_word = {hi, bus_data[7:4]};
        -> rd_ev;
        @(negedge clk);
        byte_sel = 1'b0; cs_n = 1'b1;
        @(negedge clk);
    endtask

    // Pull both selects low in the chosen order; the start edge follows.
    task automatic start_conv(input logic [11:0] v, input bit cs_last, input bit hold);
        sample_in = v;
        if (cs_last) begin rc_n = 1'b0; cs_n = 1'b1; end
        else         begin cs_n = 1'b0; rc_n = 1'b1; end
        @(negedge clk);
        cs_n = 1'b0; rc_n = 1'b0;
        @(negedge clk);
        chk("R2 busy low after start", 32'(busy), 32'd0);
        if (!hold) begin cs_n = 1'b1; rc_n = 1'b1; end
    endtask

    // Count the low cycles of busy, optionally issuing a start in the middle (R4).
    task automatic wait_done(input bit hammer, input string req);
        int n = 0;
        while (busy == 1'b0 && n < 1000) begin
            if (hammer && n == 5) begin cs_n = 1'b0; rc_n = 1'b0; end
            if (hammer && n == 8) begin cs_n = 1'b1; rc_n = 1'b1; end
            n++;
            @(negedge clk);
        end
        chk(req, 32'(n), 32'(CONV));
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rc_n = 1'b1; pwrdn = 1'b0;
        byte_sel = 1'b0; sample_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy after reset", 32'(busy), 32'd1);
        exp_q.push_back(12'h000);
        read_word();

        // R6, R11: bus disabled for the other select combinations (power-down blocks starts)
        pwrdn = 1'b1;
        cs_n = 1'b0; rc_n = 1'b0; #2;
        chk("R6 oe cs0 rc0", 32'(bus_oe), 32'd0);
        chk("R11 data cs0 rc0", 32'(bus_data), 32'd0);
        cs_n = 1'b1; rc_n = 1'b0; #2;
        chk("R6 oe cs1 rc0", 32'(bus_oe), 32'd0);
        cs_n = 1'b1; rc_n = 1'b1; #2;
        chk("R6 oe cs1 rc1", 32'(bus_oe), 32'd0);
        chk("R11 data cs1 rc1", 32'(bus_data), 32'd0);
        @(negedge clk);
        pwrdn = 1'b0;
        @(negedge clk);

        // R2, R3: rc_n falls last, max positive code
        start_conv(12'h7FF, 1'b0, 1'b0);
        wait_done(1'b0, "R3 conversion length");
        exp_q.push_back(12'h7FF);
        read_word();

        // R2, R4: cs_n falls last, starts issued mid-conversion are ignored
        start_conv(12'h800, 1'b1, 1'b0);
        wait_done(1'b1, "R4 length with ignored start");
        exp_q.push_back(12'h800);
        read_word();

        // R7, R8: explicit byte values and byte_sel switching without a clock edge
        start_conv(12'hA5C, 1'b0, 1'b0);
        wait_done(1'b0, "R3 conversion length");
        cs_n = 1'b0; rc_n = 1'b1; byte_sel = 1'b0; #2;
        chk("R7 upper byte", 32'(bus_data), 32'hA5);
        byte_sel = 1'b1; #2;
        chk("R8 lower byte", 32'(bus_data), 32'hC0);
        byte_sel = 1'b0; #2;
        chk("R7 back to upper", 32'(bus_data), 32'hA5);
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);

        // R5: selects held low through the end retrigger at once
        start_conv(12'h123, 1'b0, 1'b1);
        wait_done(1'b0, "R5 first conversion length");
        chk("R5 busy high one cycle", 32'(busy), 32'd1);
        sample_in = 12'h456;
        @(negedge clk);
        chk("R5 retriggered", 32'(busy), 32'd0);
        cs_n = 1'b1; rc_n = 1'b1;
        wait_done(1'b0, "R5 second conversion length");
        exp_q.push_back(12'h456);
        read_word();

        // R9: power-down blocks starts and keeps the result
        pwrdn = 1'b1; sample_in = 12'hFFF;
        cs_n = 1'b0; rc_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 busy stays high", 32'(busy), 32'd1);
        end
        cs_n = 1'b1; rc_n = 1'b1;
        exp_q.push_back(12'h456);
        read_word();
        pwrdn = 1'b0;
        @(negedge clk);

        // R10: power-down mid-conversion aborts and keeps the result
        start_conv(12'h001, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        pwrdn = 1'b1;
        @(negedge clk);
        chk("R10 busy after abort", 32'(busy), 32'd1);
        exp_q.push_back(12'h456);
        read_word();
        pwrdn = 1'b0;
        @(negedge clk);

        // R3: further codes, all ones and one
        start_conv(12'hFFF, 1'b1, 1'b0);
        wait_done(1'b0, "R3 conversion length");
        exp_q.push_back(12'hFFF);
        read_word();
        start_conv(12'h001, 1'b0, 1'b0);
        wait_done(1'b0, "R3 conversion length");
        exp_q.push_back(12'h001);
        read_word();

        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule